// File: doc/BRIEF.md
# Ping-Pong Frame Buffer Arbiter

This block sits between a sensor readout stream and a client that consumes whole frames. It holds two frame buffers. At any moment one of them is the write target for the incoming pixel stream and the other is the stable buffer, which holds the latest finished frame. A single ownership flag records whether the client currently holds the stable buffer. The buffers change roles only at the start of a frame, and only while the producer side holds the stable buffer. Otherwise the new frame is written over the current write buffer, and the client keeps reading an undisturbed image.

Each frame start carries the time at which a new integration window opened. The block stamps the buffer that is about to be filled with the midpoint of the window that closed: the previous start time and the new one are added, and the sum is shifted right by one bit. The client sees the stable buffer index, the stamp of that buffer and a ready flag. It reads pixels through a registered read port addressed within the stable buffer. It hands the buffer back with a release pulse. Each buffer is sized to the frame length rounded up to a multiple of four entries, so a 1546-pixel frame gets 1548 entries per buffer.

Top module: `pp_frame_arbiter`

## Requirements
- R1: After reset `stable_sel` is 1 (buffer 0 is the write target), `client_ready` is 0 and `stable_ts` is 0. The stored previous start time is also 0.
- R2: A `frame_start` pulse while `client_ready` is 0 swaps the buffers. From the next cycle `stable_sel` is inverted and `client_ready` is 1.
- R3: A `frame_start` pulse while `client_ready` is 1, with no release in the same cycle, leaves `stable_sel`, `stable_ts` and the stable buffer contents unchanged. The new frame overwrites the current write buffer.
- R4: `client_ready` falls only in the cycle after a `client_release` pulse. A release while `client_ready` is 0 has no effect on any output.
- R5: `client_ready` rises only in the cycle after a `frame_start` pulse.
- R6: On `frame_start` with time T, the buffer that receives the new frame is stamped with (Tprev + T) >> 1. The sum is formed one bit wider than `integ_time`, so a carry is not lost. Tprev then becomes T. `stable_ts` shows the stamp of the stable buffer.
- R7: When `client_release` and `frame_start` arrive in the same cycle, the release is applied first. The buffers swap and `client_ready` stays 1.
- R8: From the cycle after `frame_start`, each `pix_valid` cycle stores `pix_data` at the next entry of the write buffer, starting at entry 0. `rd_data` shows stable buffer entry `rd_addr` one cycle after the address is applied.
- R9: Pixels that arrive after `frame_done` are discarded, as are pixels beyond FRAME_LEN in one frame. Neither kind reaches either buffer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | Producer pulse: a new frame begins and the swap decision is taken |
| integ_time | input | TS_W | Start time of the integration window opened by this frame start |
| frame_done | input | 1 | Producer pulse: the pixel stream of the frame has ended |
| pix_valid | input | 1 | Pixel strobe |
| pix_data | input | PIX_W | Pixel value |
| client_release | input | 1 | Client pulse handing the stable buffer back |
| rd_addr | input | AW | Entry index within the stable buffer |
| rd_data | output | PIX_W | Registered pixel read from the stable buffer |
| client_ready | output | 1 | 1 while the client holds the stable buffer |
| stable_sel | output | 1 | Index of the stable buffer |
| stable_ts | output | TS_W | Midpoint stamp of the stable buffer |

## Verification
The properties assume that `frame_start` is a single-cycle pulse that never coincides with `pix_valid`. They also assume that `client_release` is driven only by the client. The bench follows these rules: every pulse lasts one cycle, and pixels start only one cycle after the frame start. Frame starts are placed in turn while the client holds the buffer, while it does not, and in the same cycle as a release. Pixel bursts are run short, full-length and over-length, with extra pixels after `frame_done`. The stamp carry case is reached by choosing start times close to the top of the 32-bit range.

// File: rtl/pp_arb_pkg.sv
package pp_arb_pkg;
  localparam int NBUF = 2;

  typedef logic buf_sel_t;

  function automatic int pad_to_four(input int n);
    return ((n + 3) / 4) * 4;
  endfunction
endpackage

// File: rtl/pp_owner_ctrl.sv
module pp_owner_ctrl
  import pp_arb_pkg::*;
(
  input  logic     clk,
  input  logic     rst,
  input  logic     frame_start,
  input  logic     client_release,
  output buf_sel_t wsel_q,
  output logic     owned_q,
  output buf_sel_t tgt_sel
);
  logic owned_eff;
  logic swap;

  // release is folded in before the swap decision
  assign owned_eff = owned_q & ~client_release;
  assign swap      = frame_start & ~owned_eff;
  assign tgt_sel   = swap ? ~wsel_q : wsel_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel_q  <= 1'b0;
      owned_q <= 1'b0;
    end else begin
      wsel_q  <= tgt_sel;
      owned_q <= owned_eff | frame_start;
    end
  end
endmodule

// File: rtl/pp_ts_track.sv
module pp_ts_track
  import pp_arb_pkg::*;
#(
  parameter int TS_W = 32
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            frame_start,
  input  logic [TS_W-1:0] integ_time,
  input  buf_sel_t        tgt_sel,
  input  buf_sel_t        rsel,
  output logic [TS_W-1:0] stable_ts
);
  logic [TS_W-1:0] tprev_q;
  logic [TS_W-1:0] ts_q [NBUF];
  logic [TS_W:0]   sum;
  logic [TS_W-1:0] mid;

  assign sum = {1'b0, tprev_q} + {1'b0, integ_time};
  assign mid = sum[TS_W:1];

  always_ff @(posedge clk) begin
    if (rst) begin
      tprev_q <= '0;
      for (int b = 0; b < NBUF; b++) ts_q[b] <= '0;
    end else if (frame_start) begin
      tprev_q <= integ_time;
      for (int b = 0; b < NBUF; b++)
        if (tgt_sel == 1'(b)) ts_q[b] <= mid;
    end
  end

  assign stable_ts = ts_q[rsel];
endmodule

// File: rtl/pp_pixel_store.sv
module pp_pixel_store
  import pp_arb_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int FRAME_LEN = 1546,
  parameter int DEPTH     = 1548,
  parameter int AW        = 11
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             frame_done,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  buf_sel_t         wsel,
  input  buf_sel_t         rsel,
  input  logic [AW-1:0]    rd_addr,
  output logic [PIX_W-1:0] rd_data
);
  localparam int TOTAL = NBUF * DEPTH;
  localparam int MW    = $clog2(TOTAL);
  localparam int CW    = $clog2(FRAME_LEN + 1);

  logic [PIX_W-1:0] mem [TOTAL];
  logic             in_frame_q;
  logic [CW-1:0]    wcnt_q;
  logic             wr_en;
  logic [MW-1:0]    wr_ptr;
  logic [MW-1:0]    rd_ptr;

  assign wr_en  = pix_valid & in_frame_q & (wcnt_q < CW'(FRAME_LEN));
  assign wr_ptr = (wsel ? MW'(DEPTH) : MW'(0)) + MW'(wcnt_q);
  assign rd_ptr = (rsel ? MW'(DEPTH) : MW'(0)) + MW'(rd_addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      in_frame_q <= 1'b0;
      wcnt_q     <= '0;
    end else if (frame_start) begin
      in_frame_q <= 1'b1;
      wcnt_q     <= '0;
    end else begin
      if (frame_done) in_frame_q <= 1'b0;
      if (wr_en)      wcnt_q     <= wcnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_ptr] <= pix_data;
  end

  always_ff @(posedge clk) begin
    rd_data <= mem[rd_ptr];
  end
endmodule

// File: rtl/pp_frame_arbiter.sv
module pp_frame_arbiter
  import pp_arb_pkg::*;
#(
  parameter int PIX_W     = 8,
  parameter int TS_W      = 32,
  parameter int FRAME_LEN = 1546,
  parameter int DEPTH     = pad_to_four(FRAME_LEN),
  parameter int AW        = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic [TS_W-1:0]  integ_time,
  input  logic             frame_done,
  input  logic             pix_valid,
  input  logic [PIX_W-1:0] pix_data,
  input  logic             client_release,
  input  logic [AW-1:0]    rd_addr,
  output logic [PIX_W-1:0] rd_data,
  output logic             client_ready,
  output logic             stable_sel,
  output logic [TS_W-1:0]  stable_ts
);
  buf_sel_t wsel;
  buf_sel_t tgt_sel;
  logic     owned;

  pp_owner_ctrl u_ctrl (
    .clk            (clk),
    .rst            (rst),
    .frame_start    (frame_start),
    .client_release (client_release),
    .wsel_q         (wsel),
    .owned_q        (owned),
    .tgt_sel        (tgt_sel)
  );

  pp_ts_track #(.TS_W(TS_W)) u_ts (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .integ_time  (integ_time),
    .tgt_sel     (tgt_sel),
    .rsel        (~wsel),
    .stable_ts   (stable_ts)
  );

  pp_pixel_store #(
    .PIX_W(PIX_W), .FRAME_LEN(FRAME_LEN), .DEPTH(DEPTH), .AW(AW)
  ) u_store (
    .clk         (clk),
    .rst         (rst),
    .frame_start (frame_start),
    .frame_done  (frame_done),
    .pix_valid   (pix_valid),
    .pix_data    (pix_data),
    .wsel        (wsel),
    .rsel        (~wsel),
    .rd_addr     (rd_addr),
    .rd_data     (rd_data)
  );

  assign client_ready = owned;
  assign stable_sel   = ~wsel;
endmodule

// File: rtl/pp_frame_arbiter_chk.sv
module pp_frame_arbiter_chk #(
  parameter int TS_W = 32
) (
  input logic            clk,
  input logic            rst,
  input logic            frame_start,
  input logic            client_release,
  input logic            client_ready,
  input logic            stable_sel,
  input logic [TS_W-1:0] stable_ts
);
  assert_start_grants_R2: assert property (@(posedge clk) disable iff (rst)
    frame_start |=> client_ready);

  assert_swap_when_free_R7: assert property (@(posedge clk) disable iff (rst)
    (frame_start && (!client_ready || client_release)) |=> (stable_sel != $past(stable_sel)));

  assert_hold_when_owned_R3: assert property (@(posedge clk) disable iff (rst)
    (frame_start && client_ready && !client_release) |=> ($stable(stable_sel) && $stable(stable_ts)));

  assert_keep_ready_R4: assert property (@(posedge clk) disable iff (rst)
    (client_ready && !client_release) |=> client_ready);

  assert_no_self_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (!frame_start && !client_ready) |=> !client_ready);

  assert_no_idle_move_R4: assert property (@(posedge clk) disable iff (rst)
    !frame_start |=> ($stable(stable_sel) && $stable(stable_ts)));
endmodule

bind pp_frame_arbiter pp_frame_arbiter_chk #(.TS_W(TS_W)) u_chk (
  .clk            (clk),
  .rst            (rst),
  .frame_start    (frame_start),
  .client_release (client_release),
  .client_ready   (client_ready),
  .stable_sel     (stable_sel),
  .stable_ts      (stable_ts)
);

// File: tb/sim_pp_frame_arbiter.sv
`timescale 1ns/1ps
module sim_pp_frame_arbiter;
  localparam int PIX_W = 8;
  localparam int TS_W  = 32;
  localparam int FLEN  = 10;
  localparam int DEP   = 12;
  localparam int AW    = 4;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             frame_start = 1'b0;
  logic [TS_W-1:0]  integ_time = '0;
  logic             frame_done = 1'b0;
  logic             pix_valid = 1'b0;
  logic [PIX_W-1:0] pix_data = '0;
  logic             client_release = 1'b0;
  logic [AW-1:0]    rd_addr = '0;
  logic [PIX_W-1:0] rd_data;
  logic             client_ready;
  logic             stable_sel;
  logic [TS_W-1:0]  stable_ts;

  always #2.5 clk = ~clk;

  pp_frame_arbiter #(.PIX_W(PIX_W), .TS_W(TS_W), .FRAME_LEN(FLEN), .DEPTH(DEP), .AW(AW)) u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start), .integ_time(integ_time),
    .frame_done(frame_done), .pix_valid(pix_valid), .pix_data(pix_data),
    .client_release(client_release), .rd_addr(rd_addr), .rd_data(rd_data),
    .client_ready(client_ready), .stable_sel(stable_sel), .stable_ts(stable_ts)
  );

  int          checks = 0;
  int          errors = 0;
  bit          done = 0;
  bit          reported = 0;
  int          kq[$];
  logic [31:0] vq[$];
  string       tq[$];

  // kind: 0 rd_data, 1 client_ready, 2 stable_sel, 3 stable_ts
  task automatic expect_item(input int kind, input logic [31:0] val, input string tag);
    kq.push_back(kind); vq.push_back(val); tq.push_back(tag);
  endtask

  task automatic cyc();
    @(posedge clk); #1;
    frame_start = 0; frame_done = 0; pix_valid = 0; client_release = 0;
  endtask

  task automatic expect_state(input logic rdy, input logic sel, input logic [31:0] ts, input string tag);
    expect_item(1, 32'(rdy), tag);
    expect_item(2, 32'(sel), tag);
    expect_item(3, ts, tag);
  endtask

  task automatic report();
    if (!reported) begin
      reported = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  // monitor: items queued before a rising edge are compared at the next falling edge
  always begin
    int n;
    @(posedge clk);
    n = kq.size();
    @(negedge clk);
    for (int i = 0; i < n; i++) begin
      int k; logic [31:0] e; logic [31:0] a; string t;
      k = kq.pop_front(); e = vq.pop_front(); t = tq.pop_front();
      case (k)
        0:       a = 32'(rd_data);
        1:       a = 32'(client_ready);
        2:       a = 32'(stable_sel);
        default: a = stable_ts;
      endcase
      checks++;
      if (a !== e) begin
        errors++;
        $display("FAIL %s kind %0d actual %h expected %h", t, k, a, e);
      end
    end
  end

  task automatic push_pixels(input int cnt, input logic [7:0] base);
    for (int i = 0; i < cnt; i++) begin
      cyc(); pix_valid = 1; pix_data = base + 8'(i);
    end
  endtask

  initial begin
    repeat (4) @(posedge clk);
    #1 rst = 0;
    expect_state(1'b0, 1'b1, 32'd0, "R1");

    // first frame start, producer holds stable: swap
    cyc(); frame_start = 1; integ_time = 32'd100;
    expect_state(1'b1, 1'b0, 32'd0, "R2");
    push_pixels(10, 8'h10);
    cyc(); frame_done = 1;

    cyc(); client_release = 1;
    expect_item(1, 32'd0, "R4");
    cyc(); client_release = 1;        // release while not owned
    expect_state(1'b0, 1'b0, 32'd0, "R4");
    cyc();                            // idle, ready must not rise
    expect_item(1, 32'd0, "R5");

    cyc(); frame_start = 1; integ_time = 32'd300;
    expect_state(1'b1, 1'b1, 32'd50, "R6");
    for (int i = 0; i < 10; i++) begin
      cyc(); rd_addr = AW'(i);
      expect_item(0, 32'h10 + 32'(i), "R8");
    end

    // over-length frame into buffer 0, then pixels after done
    push_pixels(14, 8'h40);
    cyc(); frame_done = 1;
    push_pixels(3, 8'h70);

    // client still holds: no swap
    cyc(); frame_start = 1; integ_time = 32'd500;
    expect_state(1'b1, 1'b1, 32'd50, "R3");
    for (int i = 0; i < 10; i++) begin
      cyc(); rd_addr = AW'(i);
      expect_item(0, 32'h10 + 32'(i), (i < 2) ? "R9" : "R3");
    end

    // short frame overwrites buffer 0, then stray pixels
    push_pixels(5, 8'h80);
    cyc(); frame_done = 1;
    push_pixels(3, 8'hE0);

    // release and start together: release first, swap happens
    cyc(); client_release = 1; frame_start = 1; integ_time = 32'hFFFF_FF00;
    expect_state(1'b1, 1'b0, 32'd400, "R7");
    for (int i = 0; i < 10; i++) begin
      cyc(); rd_addr = AW'(i);
      if (i < 5) expect_item(0, 32'h80 + 32'(i), "R3");
      else       expect_item(0, 32'h40 + 32'(i), "R9");
    end

    cyc(); client_release = 1;
    expect_item(1, 32'd0, "R4");
    cyc();
    expect_state(1'b0, 1'b0, 32'd400, "R5");

    // carry in midpoint sum
    cyc(); frame_start = 1; integ_time = 32'hFFFF_FFFE;
    expect_state(1'b1, 1'b1, 32'h8000_007A, "R6");
    cyc(); client_release = 1;
    expect_item(1, 32'd0, "R4");
    cyc(); frame_start = 1; integ_time = 32'h10;
    expect_state(1'b1, 1'b0, 32'hFFFF_FF7F, "R6");

    cyc(); cyc(); cyc();
    done = 1;
    report();
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired, actual running expected finished");
      report();
    end
  end
endmodule